// File: doc/BRIEF.md
# Dual-Chip-Select SPI Controller

This block is an SPI controller driven through four byte-wide registers. It drives a serial clock, a serial data output and two active-low chip selects, and it samples a serial data input. Software sets the clock idle level, the sampling edge, an even clock division ratio, a frame length of 1 to 8 bits and the transfer direction. It then launches each frame with a command bit that names one of the two chip selects.

The chosen chip select stays asserted from frame to frame, so one transaction can span any number of separately launched frames. The transaction closes only through a two-step end command: first a request, then a release.

An optional blocking mode holds one start command that arrives while a frame is still shifting, and launches it as soon as that frame completes.

Register map (address: content):
- 0, configuration: bit 6 clock idle level (cpol), bit 5 sampling edge (cpha), bits [4:2] divider field.
- 1, frame: bits [5:3] length, bit 2 direction, bit 1 blocking.
- 2: data.
- 3, command/status. On a write: bit 4 starts a frame on chip select 0, bit 3 starts a frame on chip select 1, bit 5 raises the end request, bit 1 releases. On a read: bit 5 end request pending, bit 4 chip select 0 held, bit 3 chip select 1 held, bit 0 busy.

Configuration and frame bits not listed read as 0. Register reads are combinational.

Top module: `spi_dualcs_ctrl`

## Requirements
- R1: After reset, cs_n is 2'b11, sck is low, and the status and data registers read 8'h00.
- R2: While a frame is active, each sck level lasts (field+1) clock cycles, where the field is configuration bits [4:2]. This gives an sck period of 2×(field+1) cycles.
- R3: While no frame is active, sck sits at the level of configuration bit 6. Configuration bit 5 = 0 samples miso on the first sck edge of each bit and changes mosi on the second edge. Bit 5 = 1 changes mosi on the first edge and samples miso on the second.
- R4: In a write cycle (frame bit 2 = 0), the frame sends the low n bits of the data register, bit n-1 first. n is frame bits [5:3], and the value 0 means 8. Exactly n sck leading edges occur per frame.
- R5: In a read cycle (frame bit 2 = 1), mosi is held low. The n bits sampled from miso are stored in the low n bits of the data register, with the first bit sampled in the highest of them, and the upper bits are cleared.
- R6: Writing command bit 4 asserts cs_n[0] and writing command bit 3 asserts cs_n[1]. If both bits are written together, chip select 0 wins. At most one chip select is ever low, and a start on the other chip select switches to it.
- R7: The chosen chip select stays low after a frame ends and across later frames, and status bit 4 or bit 3 shows which one is held.
- R8: Command bit 5 sets the end request, which reads back as status bit 5. Command bit 1, written while the request is set and no frame is busy, raises both chip selects and clears the request. Command bit 1 with no request pending changes nothing.
- R9: Status bit 0 reads 1 from the cycle after a start command until the last bit of the frame is complete. The received data is readable once it reads 0.
- R10: With frame bit 1 = 1, a start written during a busy frame is held and launched as soon as the current frame completes, so both frames are sent in order.
- R11: With frame bit 1 = 0, a start written during a busy frame is ignored.
- R12: Command bit 1 written while a frame is busy is ignored: the end request stays set and the chip select stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 2 | Active-low chip selects |

## Verification
The bench models a target that shifts on the opposite edge to the one the controller samples on. If the controller sampled on the wrong edge, the read data would come back shifted by one bit. Short frames with the upper data bits set catch a design that sends from bit 7 instead of bit n-1, or that leaves stale upper bits after a read. Back-to-back starts in both blocking modes catch a design that drops the queued frame, or one that sends an extra frame when starts should be ignored; counting sck leading edges exposes either fault. The end-sequence tests issue a release with no request pending and a release while a frame is busy. A design that decoded the end command too loosely would drop the chip select in the middle of a transaction.

// File: rtl/spi_dualcs_ctrl.sv
module spi_dualcs_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       sck,
  output logic       mosi,
  input  logic       miso,
  output logic [1:0] cs_n
);
  localparam logic [1:0] A_CFG = 2'd0, A_FRM = 2'd1, A_DAT = 2'd2, A_CMD = 2'd3;

  logic [4:0] cfg;
  logic [4:0] frm;
  logic [7:0] dat;
  logic       cpol, cpha, rd_sel, blk;
  logic [2:0] div_sel, wsel;
  assign {cpol, cpha, div_sel} = cfg;
  assign {wsel, rd_sel, blk}   = frm;

  logic       run, pend, pend_cs, sel, cs_act, endreq, half, frame_rd;
  logic       sck_r, mosi_r;
  logic [2:0] cnt;
  logic [3:0] left;
  logic [7:0] txs, rxs;

  logic busy;
  assign busy = run | pend;

  logic cmd_wr, go0, go1, go, go_cs, tick, last;
  logic launch_now, launch_pend, launch, launch_cs;
  logic [3:0] nbits;
  logic [7:0] rx_next, tx_load;

  assign cmd_wr      = reg_we && (reg_addr == A_CMD);
  assign go0         = cmd_wr && reg_wdata[4];
  assign go1         = cmd_wr && reg_wdata[3];
  assign go          = go0 | go1;
  assign go_cs       = !go0;
  assign tick        = run && (cnt == div_sel);
  assign last        = tick && half && (left == 4'd1);
  assign rx_next     = {rxs[6:0], miso};
  assign nbits       = (wsel == 3'd0) ? 4'd8 : {1'b0, wsel};
  assign launch_now  = go && !busy;
  assign launch_pend = pend && (!run || last);
  assign launch      = launch_now | launch_pend;
  assign launch_cs   = launch_pend ? pend_cs : go_cs;
  assign tx_load     = rd_sel ? 8'h00 : (dat << (4'd8 - nbits));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= '0;
      frm      <= '0;
      dat      <= '0;
      run      <= 1'b0;
      pend     <= 1'b0;
      pend_cs  <= 1'b0;
      sel      <= 1'b0;
      cs_act   <= 1'b0;
      endreq   <= 1'b0;
      half     <= 1'b0;
      frame_rd <= 1'b0;
      sck_r    <= 1'b0;
      mosi_r   <= 1'b0;
      cnt      <= '0;
      left     <= '0;
      txs      <= '0;
      rxs      <= '0;
    end else begin
      if (reg_we && reg_addr == A_CFG) cfg <= reg_wdata[6:2];
      if (reg_we && reg_addr == A_FRM) frm <= reg_wdata[5:1];
      if (reg_we && reg_addr == A_DAT) dat <= reg_wdata;

      if (cmd_wr) begin
        if (reg_wdata[1] && endreq && !busy && !go) begin
          cs_act <= 1'b0;
          endreq <= 1'b0;
        end else if (reg_wdata[5]) begin
          endreq <= 1'b1;
        end
      end

      if (tick) begin
        cnt  <= '0;
        half <= ~half;
        if (!half) begin
          sck_r <= ~cpol;
          if (!cpha) rxs <= rx_next;
          else begin
            mosi_r <= txs[7];
            txs    <= {txs[6:0], 1'b0};
          end
        end else begin
          sck_r <= cpol;
          left  <= left - 4'd1;
          if (cpha) rxs <= rx_next;
          else begin
            mosi_r <= txs[7];
            txs    <= {txs[6:0], 1'b0};
          end
          if (left == 4'd1) begin
            run <= 1'b0;
            if (frame_rd) dat <= cpha ? rx_next : rxs;
          end
        end
      end else if (run) begin
        cnt <= cnt + 3'd1;
      end

      if (go && busy && blk && !pend) begin
        pend    <= 1'b1;
        pend_cs <= go_cs;
      end

      if (launch) begin
        run      <= 1'b1;
        cnt      <= '0;
        half     <= 1'b0;
        left     <= nbits;
        sck_r    <= cpol;
        frame_rd <= rd_sel;
        rxs      <= '0;
        mosi_r   <= tx_load[7];
        txs      <= cpha ? tx_load : {tx_load[6:0], 1'b0};
        sel      <= launch_cs;
        cs_act   <= 1'b1;
        if (launch_pend) pend <= 1'b0;
      end
    end
  end

  assign sck  = run ? sck_r : cpol;
  assign mosi = mosi_r;
  assign cs_n = !cs_act ? 2'b11 : (sel ? 2'b01 : 2'b10);

  always_comb begin
    case (reg_addr)
      A_CFG:   reg_rdata = {1'b0, cfg, 2'b00};
      A_FRM:   reg_rdata = {2'b00, frm, 1'b0};
      A_DAT:   reg_rdata = dat;
      default: reg_rdata = {2'b00, endreq, cs_act & !sel, cs_act & sel, 2'b00, busy};
    endcase
  end
endmodule

// File: rtl/spi_dualcs_ctrl_chk.sv
module spi_dualcs_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       sck,
  input logic       mosi,
  input logic [1:0] cs_n,
  input logic       busy,
  input logic       run,
  input logic       frame_rd,
  input logic       cpol,
  input logic       endreq
);
  AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n) $countones(~cs_n) <= 1); // R6
  AST_SCK_IDLE_AT_END: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> sck == cpol); // R3
  AST_CS_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy |-> cs_n != 2'b11); // R7
  AST_READ_MOSI_LOW: assert property (@(posedge clk) disable iff (!rst_n) (run && frame_rd) |-> !mosi); // R5
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd3 && (reg_wdata[4] || reg_wdata[3]) && !busy) |=> busy); // R9
  AST_END_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd3 && reg_wdata[1] && !reg_wdata[4] && !reg_wdata[3] && endreq && !busy)
    |=> (cs_n == 2'b11 && !endreq)); // R8
  AST_BUSY_RELEASE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd3 && reg_wdata[1] && endreq && busy) |=> endreq); // R12
endmodule

bind spi_dualcs_ctrl spi_dualcs_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .sck(sck), .mosi(mosi), .cs_n(cs_n), .busy(busy), .run(run), .frame_rd(frame_rd),
  .cpol(cpol), .endreq(endreq)
);

// File: tb/test_spi_dualcs_ctrl.sv
module test_spi_dualcs_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       sck, mosi;
  logic       miso = 1'b0;
  logic [1:0] cs_n;

  spi_dualcs_ctrl i_spi_dualcs_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic        tb_cpol = 1'b0, tb_cpha = 1'b0;
  logic [7:0]  tgt = 8'h00;
  int          tidx = 0;
  logic [15:0] cap = '0;
  int          lead_n = 0;

  always @(sck) begin
    if (rst_n && cs_n != 2'b11) begin
      if (sck != tb_cpol) begin
        lead_n++;
        if (tb_cpha) begin
          if (tidx >= 0) miso = tgt[tidx];
          tidx--;
        end else cap = {cap[14:0], mosi};
      end else begin
        if (tb_cpha) cap = {cap[14:0], mosi};
        else begin
          tidx--;
          if (tidx >= 0) miso = tgt[tidx];
        end
      end
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_cfg(input logic p, input logic h, input logic [2:0] dv);
    tb_cpol = p; tb_cpha = h;
    wr(2'd0, {1'b0, p, h, dv, 2'b00});
  endtask

  task automatic set_frm(input logic [2:0] w, input logic r, input logic b);
    wr(2'd1, {2'b00, w, r, b, 1'b0});
  endtask

  task automatic arm(input logic [7:0] v, input int n);
    tgt = v; tidx = n - 1; cap = '0; lead_n = 0;
    miso = tb_cpha ? 1'b0 : v[n-1];
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    int k = 0;
    s = 8'h01;
    while (s[0] && k < 5000) begin
      rd(2'd3, s);
      k++;
    end
    if (k >= 5000) begin
      checks++; errors++;
      $display("FAIL R9: busy never cleared, actual 1 expected 0");
    end
  endtask

  task automatic end_xfer();
    wr(2'd3, 8'h20);
    wr(2'd3, 8'h02);
  endtask

  task automatic t_reset();
    logic [7:0] s;
    check("R1 cs_n", {14'd0, cs_n}, 16'h3);
    check("R1 sck", {15'd0, sck}, 16'h0);
    rd(2'd3, s); check("R1 status", {8'd0, s}, 16'h00);
    rd(2'd2, s); check("R1 data", {8'd0, s}, 16'h00);
  endtask

  task automatic t_write_mode0();
    logic [7:0] s;
    set_cfg(1'b0, 1'b0, 3'd1);
    set_frm(3'd0, 1'b0, 1'b0);
    wr(2'd2, 8'hA5);
    arm(8'h00, 8);
    wr(2'd3, 8'h10);
    rd(2'd3, s); check("R9 busy set", {15'd0, s[0]}, 16'h1);
    check("R6 cs0 low", {14'd0, cs_n}, 16'h2);
    wait_idle();
    check("R4 write data", cap, 16'h00A5);
    check("R4 edge count", lead_n[15:0], 16'd8);
    check("R7 cs held", {14'd0, cs_n}, 16'h2);
    check("R3 sck idle low", {15'd0, sck}, 16'h0);
    rd(2'd3, s); check("R7 status cs0", {8'd0, s}, 16'h10);
    end_xfer();
  endtask

  task automatic t_read_mode3();
    logic [7:0] s;
    set_cfg(1'b1, 1'b1, 3'd0);
    set_frm(3'd0, 1'b1, 1'b0);
    arm(8'h3C, 8);
    wr(2'd3, 8'h08);
    check("R6 cs1 low", {14'd0, cs_n}, 16'h1);
    wait_idle();
    rd(2'd2, s); check("R5 read data", {8'd0, s}, 16'h3C);
    check("R5 mosi low", cap, 16'h0000);
    check("R3 sck idle high", {15'd0, sck}, 16'h1);
    rd(2'd3, s); check("R7 status cs1", {8'd0, s}, 16'h08);
    end_xfer();
  endtask

  task automatic t_short();
    logic [7:0] s;
    set_cfg(1'b0, 1'b1, 3'd2);
    set_frm(3'd5, 1'b0, 1'b0);
    wr(2'd2, 8'hFB);
    arm(8'h00, 5);
    wr(2'd3, 8'h10);
    wait_idle();
    check("R4 5-bit write", cap, 16'h001B);
    check("R4 5-bit edges", lead_n[15:0], 16'd5);
    end_xfer();
    set_cfg(1'b1, 1'b0, 3'd0);
    set_frm(3'd3, 1'b1, 1'b0);
    arm(8'h05, 3);
    wr(2'd3, 8'h10);
    wait_idle();
    rd(2'd2, s); check("R5 3-bit read", {8'd0, s}, 16'h05);
    check("R4 3-bit edges", lead_n[15:0], 16'd3);
    end_xfer();
  endtask

  task automatic t_div();
    for (int d = 0; d < 8; d += 3) begin
      int n;
      set_cfg(1'b0, 1'b0, d[2:0]);
      set_frm(3'd2, 1'b0, 1'b0);
      arm(8'h00, 2);
      wr(2'd3, 8'h10);
      n = 0;
      while (sck == 1'b0 && n < 100) begin @(negedge clk); n++; end
      n = 0;
      while (sck == 1'b1 && n < 100) begin @(negedge clk); n++; end
      check("R2 half period", n[15:0], d[15:0] + 16'd1);
      wait_idle();
      end_xfer();
    end
  endtask

  task automatic t_end();
    logic [7:0] s;
    set_cfg(1'b0, 1'b0, 3'd3);
    set_frm(3'd0, 1'b0, 1'b0);
    arm(8'h00, 8);
    wr(2'd3, 8'h10);
    wait_idle();
    wr(2'd3, 8'h02);
    check("R8 release w/o request", {14'd0, cs_n}, 16'h2);
    wr(2'd3, 8'h20);
    rd(2'd3, s); check("R8 request flag", {8'd0, s}, 16'h30);
    check("R8 cs held on request", {14'd0, cs_n}, 16'h2);
    wr(2'd3, 8'h10);
    wr(2'd3, 8'h02);
    rd(2'd3, s); check("R12 release while busy", {8'd0, s[5], s[4], 6'd0}, 16'h00C0);
    wait_idle();
    check("R12 cs still low", {14'd0, cs_n}, 16'h2);
    wr(2'd3, 8'h02);
    check("R8 cs released", {14'd0, cs_n}, 16'h3);
    rd(2'd3, s); check("R8 status cleared", {8'd0, s}, 16'h00);
  endtask

  task automatic t_block();
    set_cfg(1'b0, 1'b0, 3'd0);
    set_frm(3'd0, 1'b0, 1'b1);
    wr(2'd2, 8'h81);
    arm(8'h00, 8);
    wr(2'd3, 8'h10);
    wr(2'd2, 8'h42);
    wr(2'd3, 8'h10);
    wait_idle();
    check("R10 queued frames", cap, 16'h8142);
    check("R10 edge count", lead_n[15:0], 16'd16);
    end_xfer();
    set_frm(3'd0, 1'b0, 1'b0);
    wr(2'd2, 8'h81);
    arm(8'h00, 8);
    wr(2'd3, 8'h10);
    wr(2'd2, 8'h42);
    wr(2'd3, 8'h10);
    wait_idle();
    repeat (40) @(negedge clk);
    check("R11 start ignored edges", lead_n[15:0], 16'd8);
    check("R11 data", cap, 16'h0081);
    end_xfer();
  endtask

  task automatic t_both();
    wr(2'd3, 8'h18);
    check("R6 cs0 priority", {14'd0, cs_n}, 16'h2);
    wait_idle();
    wr(2'd3, 8'h08);
    check("R6 switch to cs1", {14'd0, cs_n}, 16'h1);
    wait_idle();
    end_xfer();
    check("R8 both released", {14'd0, cs_n}, 16'h3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_mode0();
    t_read_mode3();
    t_short();
    t_div();
    t_end();
    t_block();
    t_both();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule